// File: doc/BRIEF.md
# Boot Vector Area Remap Unit

This block sits between the CPU's code-fetch address and the program memory. It holds one 8-bit remap configuration register on a simple special-function-register bus. It redirects the lowest part of the fetch address space, which holds the reset and interrupt vectors and the boot entry, to another region of program memory. Software writes a new configuration at any time. The configuration starts to steer fetches only when a CPU-only software reset pulse arrives. The CPU then restarts from the redirected region.

There are two translation modes. In the wide mode, logical fetch addresses 0000H to 0FFFH of segment 0 are served from a 4 KB region. That region's segment and upper address nibble come from the register. In the boot mode, only 0000H to 03FFH are redirected, and address bits 11:10 of the target are forced to 11b. A nibble of FH therefore lands on the boot area at FC00H. A boot pin sampled during system reset selects that boot-area mapping without any software involvement.

Top module: `vecRemap`

## Requirements
- R1: While system reset is applied, and after it is released with the boot pin low, the register reads 00H and every fetch address passes through unchanged.
- R2: The register sits at SFR address F0ECH. A write to that address stores the write data, and a read of it returns the stored value. Writes to other addresses change nothing, and the read data is 00H whenever the register is not being read.
- R3: A register write does not change the translation. The active translation takes the stored value only at a clock edge where the CPU-only reset pulse is high.
- R4: With bit 7 of the active value clear, a segment-0 fetch address below 1000H maps to {bits 6:4, bits 3:0, address[11:0]}. The result is 19 bits wide: a 3-bit segment, then a 4-bit nibble, then a 12-bit offset.
- R5: With bit 7 of the active value set, a segment-0 fetch address below 0400H maps to {bits 6:4, bits 3:0, 2'b11, address[9:0]}. Segment-0 addresses from 0400H to 0FFFH pass through unchanged.
- R6: Any fetch with a nonzero segment, and any fetch above the active window, produces {segment, address} unchanged.
- R7: If the boot pin is high during system reset, the active translation becomes boot mode with segment 0 and nibble FH, so fetch 0000H maps to physical FC00H. The register still reads 00H.
- R8: A read returns the stored register value even when it differs from the active translation.
- R9: The translation is combinational. The physical address follows a change of the fetch inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | Synchronous system reset, active low |
| cpuSwRst | input | 1 | CPU-only software reset pulse, active high |
| bootPin | input | 1 | Hardware boot selection, sampled during system reset |
| sfrWr | input | 1 | Register bus write strobe |
| sfrRd | input | 1 | Register bus read strobe |
| sfrAddr | input | 16 | Register bus address |
| sfrWdata | input | 8 | Register bus write data |
| sfrRdata | output | 8 | Register bus read data |
| fetchSeg | input | 3 | Logical fetch segment |
| fetchAddr | input | 16 | Logical fetch address |
| physAddr | output | 19 | Physical program memory address |

## Verification
The assertions check on every cycle that the physical address is a pure pass-through for nonzero segments and above 0FFFH, and that its low ten bits always follow the fetch address. They also check that the address stays stable unless a CPU-only reset or a fetch change intervenes, that the idle read data is zero, that a read right after a write returns the written byte, and that a boot-pin reset lands on FC00H. Only the bench's scenarios can show the exact mapped values for each configuration across swept fetch addresses and segments. The same holds for the delayed take-over of a written value, for the readback diverging from the active translation, and for boundary addresses such as 03FFH, 0400H, 0FFFH and 1000H.

// File: rtl/vecRemapPkg.sv
package vecRemapPkg;
  localparam int ADDR_W  = 16;
  localparam int SEG_W   = 3;
  localparam int WIN_W   = 12;
  localparam int BOOT_W  = 10;
  localparam int NIB_W   = ADDR_W - WIN_W;
  localparam int CFG_W   = 1 + SEG_W + NIB_W;
  localparam int PHYS_W  = SEG_W + ADDR_W;

  typedef struct packed {
    logic             boot;
    logic [SEG_W-1:0] seg;
    logic [NIB_W-1:0] upper;
  } remapCfg_t;

  typedef struct packed {
    logic sysClr;
    logic hwBoot;
    logic shadowWr;
    logic activeLd;
  } remapStrobe_t;

  localparam remapCfg_t HW_BOOT_CFG = '{boot: 1'b1, seg: '0, upper: '1};
endpackage

// File: rtl/vecRemapCtrl.sv
module vecRemapCtrl
  import vecRemapPkg::*;
#(
  parameter int SFR_AW = 16,
  parameter logic [SFR_AW-1:0] REG_ADDR = 16'hF0EC
) (
  input  logic              sysRstN,
  input  logic              cpuSwRst,
  input  logic              bootPin,
  input  logic              sfrWr,
  input  logic              sfrRd,
  input  logic [SFR_AW-1:0] sfrAddr,
  output remapStrobe_t      strobe,
  output logic              readSel
);
  logic regHit;

  always_comb begin
    regHit          = (sfrAddr == REG_ADDR);
    strobe.sysClr   = !sysRstN;
    strobe.hwBoot   = !sysRstN && bootPin;
    strobe.shadowWr = sysRstN && sfrWr && regHit;
    strobe.activeLd = sysRstN && cpuSwRst;
    readSel         = sfrRd && regHit;
  end
endmodule

// File: rtl/vecRemapDp.sv
module vecRemapDp
  import vecRemapPkg::*;
(
  input  logic              clk,
  input  remapStrobe_t      strobe,
  input  logic              readSel,
  input  logic [CFG_W-1:0]  sfrWdata,
  output logic [CFG_W-1:0]  sfrRdata,
  input  logic [SEG_W-1:0]  fetchSeg,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [PHYS_W-1:0] physAddr
);
  remapCfg_t shadowCfg;
  remapCfg_t activeCfg;
  logic             inWindow;
  logic [WIN_W-1:0] offset;

  always_ff @(posedge clk) begin
    if (strobe.sysClr) begin
      shadowCfg <= '0;
      activeCfg <= strobe.hwBoot ? HW_BOOT_CFG : remapCfg_t'('0);
    end else begin
      if (strobe.shadowWr) shadowCfg <= remapCfg_t'(sfrWdata);
      if (strobe.activeLd) activeCfg <= shadowCfg;
    end
  end

  always_comb begin
    offset = fetchAddr[WIN_W-1:0];
    if (activeCfg.boot) begin
      inWindow = (fetchSeg == '0) && (fetchAddr[ADDR_W-1:BOOT_W] == '0);
      offset[WIN_W-1:BOOT_W] = '1;
    end else begin
      inWindow = (fetchSeg == '0) && (fetchAddr[ADDR_W-1:WIN_W] == '0);
    end
    physAddr = inWindow ? {activeCfg.seg, activeCfg.upper, offset}
                        : {fetchSeg, fetchAddr};
    sfrRdata = readSel ? shadowCfg : '0;
  end
endmodule

// File: rtl/vecRemap.sv
module vecRemap
  import vecRemapPkg::*;
#(
  parameter int SFR_AW = 16,
  parameter logic [SFR_AW-1:0] REG_ADDR = 16'hF0EC
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              cpuSwRst,
  input  logic              bootPin,
  input  logic              sfrWr,
  input  logic              sfrRd,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [CFG_W-1:0]  sfrWdata,
  output logic [CFG_W-1:0]  sfrRdata,
  input  logic [SEG_W-1:0]  fetchSeg,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [PHYS_W-1:0] physAddr
);
  remapStrobe_t strobe;
  logic         readSel;

  vecRemapCtrl #(.SFR_AW(SFR_AW), .REG_ADDR(REG_ADDR)) u_ctrl (
    .sysRstN (sysRstN),
    .cpuSwRst(cpuSwRst),
    .bootPin (bootPin),
    .sfrWr   (sfrWr),
    .sfrRd   (sfrRd),
    .sfrAddr (sfrAddr),
    .strobe  (strobe),
    .readSel (readSel)
  );

  vecRemapDp u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .readSel  (readSel),
    .sfrWdata (sfrWdata),
    .sfrRdata (sfrRdata),
    .fetchSeg (fetchSeg),
    .fetchAddr(fetchAddr),
    .physAddr (physAddr)
  );
endmodule

// File: rtl/vecRemapChk.sv
module vecRemapChk
  import vecRemapPkg::*;
#(
  parameter int SFR_AW = 16,
  parameter logic [SFR_AW-1:0] REG_ADDR = 16'hF0EC
) (
  input logic              clk,
  input logic              sysRstN,
  input logic              cpuSwRst,
  input logic              bootPin,
  input logic              sfrWr,
  input logic              sfrRd,
  input logic [SFR_AW-1:0] sfrAddr,
  input logic [CFG_W-1:0]  sfrWdata,
  input logic [CFG_W-1:0]  sfrRdata,
  input logic [SEG_W-1:0]  fetchSeg,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic [PHYS_W-1:0] physAddr
);
  assert_seg_pass_R6: assert property (@(posedge clk) disable iff (!sysRstN)
    (fetchSeg != '0) |-> (physAddr == {fetchSeg, fetchAddr}));

  assert_high_pass_R6: assert property (@(posedge clk) disable iff (!sysRstN)
    (fetchSeg == '0 && fetchAddr[ADDR_W-1:WIN_W] != '0) |-> (physAddr == {fetchSeg, fetchAddr}));

  assert_low_bits_R4: assert property (@(posedge clk) disable iff (!sysRstN)
    physAddr[BOOT_W-1:0] == fetchAddr[BOOT_W-1:0]);

  assert_hold_until_swreset_R3: assert property (@(posedge clk) disable iff (!sysRstN)
    ($stable(fetchSeg) && $stable(fetchAddr) && $past(sysRstN) && !$past(cpuSwRst))
      |-> $stable(physAddr));

  assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!sysRstN)
    !(sfrRd && sfrAddr == REG_ADDR) |-> (sfrRdata == '0));

  assert_readback_R2: assert property (@(posedge clk) disable iff (!sysRstN)
    (sfrWr && sfrAddr == REG_ADDR)
      |=> (!(sfrRd && sfrAddr == REG_ADDR) || sfrRdata == $past(sfrWdata)));

  assert_hw_boot_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    ($past(!sysRstN && bootPin) && fetchSeg == '0 && fetchAddr[ADDR_W-1:BOOT_W] == '0)
      |-> (physAddr == {3'b000, 4'hF, 2'b11, fetchAddr[BOOT_W-1:0]}));

  always_comb begin
    if (sysRstN && cpuSwRst === 1'bx) begin
      assert_swreset_known_R3: assert (0);
    end
  end
endmodule

bind vecRemap vecRemapChk #(.SFR_AW(SFR_AW), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/vecRemap_bench.sv
module vecRemap_bench;
  logic        clk = 1'b0;
  logic        sysRstN = 1'b0;
  logic        cpuSwRst = 1'b0;
  logic        bootPin = 1'b0;
  logic        sfrWr = 1'b0;
  logic        sfrRd = 1'b0;
  logic [15:0] sfrAddr = '0;
  logic [7:0]  sfrWdata = '0;
  logic [7:0]  sfrRdata;
  logic [2:0]  fetchSeg = '0;
  logic [15:0] fetchAddr = '0;
  logic [18:0] physAddr;

  int nChecks = 0;
  int nErrors = 0;
  logic [7:0] modelShadow = '0;
  logic [7:0] modelActive = '0;

  always #10 clk = ~clk;

  vecRemap u_vecRemap (
    .clk(clk), .sysRstN(sysRstN), .cpuSwRst(cpuSwRst), .bootPin(bootPin),
    .sfrWr(sfrWr), .sfrRd(sfrRd), .sfrAddr(sfrAddr), .sfrWdata(sfrWdata),
    .sfrRdata(sfrRdata), .fetchSeg(fetchSeg), .fetchAddr(fetchAddr),
    .physAddr(physAddr)
  );

  function automatic logic [18:0] expPhys(logic [7:0] cfg, logic [2:0] s, logic [15:0] a);
    logic [18:0] r;
    r = {s, a};
    if (s == 3'd0) begin
      if (cfg[7] && a < 16'h0400) r = {cfg[6:4], cfg[3:0], 2'b11, a[9:0]};
      else if (!cfg[7] && a < 16'h1000) r = {cfg[6:4], cfg[3:0], a[11:0]};
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset(logic pin);
    @(negedge clk);
    sysRstN = 1'b0; bootPin = pin;
    repeat (3) @(negedge clk);
    sysRstN = 1'b1; bootPin = 1'b0;
    modelShadow = '0;
    modelActive = pin ? 8'h8F : 8'h00;
  endtask

  task automatic wrReg(logic [15:0] addr, logic [7:0] data);
    @(negedge clk);
    sfrWr = 1'b1; sfrAddr = addr; sfrWdata = data;
    @(negedge clk);
    sfrWr = 1'b0;
    if (addr == 16'hF0EC) modelShadow = data;
  endtask

  task automatic rdCheck(string req, logic [15:0] addr, logic [7:0] exp);
    @(negedge clk);
    sfrRd = 1'b1; sfrAddr = addr;
    #1 check(req, {24'd0, sfrRdata}, {24'd0, exp});
    sfrRd = 1'b0;
  endtask

  task automatic swReset();
    @(negedge clk);
    cpuSwRst = 1'b1;
    @(negedge clk);
    cpuSwRst = 1'b0;
    modelActive = modelShadow;
  endtask

  task automatic probe(string req, logic [2:0] s, logic [15:0] a);
    fetchSeg = s; fetchAddr = a;
    #1 check(req, {13'd0, physAddr}, {13'd0, expPhys(modelActive, s, a)});
  endtask

  task automatic sweep(string req);
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 40; k++) probe(req, 3'(s), 16'(k * 16'h0677));
      probe(req, 3'(s), 16'h03FF);
      probe(req, 3'(s), 16'h0400);
      probe(req, 3'(s), 16'h0FFF);
      probe(req, 3'(s), 16'h1000);
    end
  endtask

  initial begin
    #4_000_000;
    nErrors++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] cfgList [7];
    cfgList = '{8'h0B, 8'h1B, 8'h8F, 8'h9F, 8'h85, 8'h73, 8'h00};

    // R1: state during and after reset with the pin low
    @(negedge clk);
    sfrRd = 1'b1; sfrAddr = 16'hF0EC;
    #1 check("R1", {24'd0, sfrRdata}, 32'd0);
    sfrRd = 1'b0;
    doReset(1'b0);
    rdCheck("R1", 16'hF0EC, 8'h00);
    sweep("R1");

    // R2: decode of the register address
    wrReg(16'hF0ED, 8'h55);
    rdCheck("R2", 16'hF0EC, 8'h00);
    wrReg(16'hF0EC, 8'hA6);
    rdCheck("R2", 16'hF0EC, 8'hA6);
    rdCheck("R2", 16'hF0ED, 8'h00);
    check("R2", {24'd0, sfrRdata}, 32'd0);
    wrReg(16'hF0EC, 8'h00);

    foreach (cfgList[i]) begin
      wrReg(16'hF0EC, cfgList[i]);
      rdCheck("R2", 16'hF0EC, cfgList[i]);
      // R3: old active translation still steers fetches
      for (int k = 0; k < 16; k++) probe("R3", 3'd0, 16'(k * 16'h0101));
      swReset();
      sweep(cfgList[i][7] ? "R5" : "R4");
      sweep("R6");
      // R8: readback shows the newly stored value, translation unchanged
      wrReg(16'hF0EC, ~cfgList[i]);
      rdCheck("R8", 16'hF0EC, ~cfgList[i]);
      probe("R8", 3'd0, 16'h0123);
      wrReg(16'hF0EC, cfgList[i]);
    end

    // R9: output follows a fetch change within one clock phase
    wrReg(16'hF0EC, 8'h1B);
    swReset();
    @(posedge clk);
    #2 probe("R9", 3'd0, 16'h0ABC);
    check("R9", {13'd0, physAddr}, {13'd0, 19'h1BABC});
    fetchAddr = 16'h2ABC;
    #1 check("R9", {13'd0, physAddr}, {13'd0, 19'h02ABC});

    // R7: hardware boot selection at system reset
    doReset(1'b1);
    rdCheck("R7", 16'hF0EC, 8'h00);
    probe("R7", 3'd0, 16'h0000);
    check("R7", {13'd0, physAddr}, {13'd0, 19'h0FC00});
    sweep("R7");
    swReset();
    sweep("R7");
    doReset(1'b0);
    sweep("R1");

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule